// File: doc/BRIEF.md
# Register Write-Hazard Scoreboard

This block tracks outstanding register writes for an in-order issue stage that serves one register file. Each register has one pending-write bit. An issued instruction sets the bit of every valid destination register. A write port that completes a result clears the bit of its register. From this state, and from the request the decoder presents, the block decides whether that request may issue in the current cycle.

A request is issued in the cycle where `iss_valid_i` is high and `stall_o` is low. Four things can stall a request:
- a destination that is already pending (write-after-write);
- a valid source that is still pending (read-after-write);
- a unit class that needs the pipeline drained before it starts;
- a busy interlock left by a unit class that must execute alone.

While the decoder is stalled it keeps presenting the same request. A mode input can turn overlap off. The pending vector is then held at zero, and every instruction runs under a plain busy interlock. On each issue the source register numbers are captured together with their valid flags and presented to the register-file read side.

Top module: `hz_scoreboard`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pend_o` is all zero, `rd_vld_o` and `rd_num_o` are zero, and `stall_o` is low when no request is presented.
- R2: An issued instruction sets `pend_o[n]` on the next clock edge for each destination slot whose valid bit is set, where n is that slot's register number. Both destination slots can set bits in the same cycle. A slot whose valid bit is low sets nothing.
- R3: Each write port with `wb_vld_i[k]` high clears `pend_o` for its register on the next edge. Several ports can clear in the same cycle. If a register is set by an issue and cleared by a write port in the same cycle, the clear wins and the bit reads zero.
- R4: With overlap on, a request with any valid destination whose pending bit is set raises `stall_o`. The stall lasts until that bit has cleared.
- R5: With overlap on, a request with any valid source whose pending bit is set raises `stall_o`. A source whose valid flag is low is never checked.
- R6: On the edge that ends an issue cycle, `rd_vld_o` takes the request's source valid flags and `rd_num_o` takes the source numbers. Each slot is 5 bits wide, with slot 0 in the low bits. A slot whose flag is low reads zero. These outputs hold until the next issue.
- R7: Unit classes 1, 2 and 3 (memory access, branch, trap) raise `stall_o` while any pending bit is set. Once issued, they set a busy interlock that stalls every request until `unit_done_i` is seen.
- R8: Unit classes 4 and 5 (address translation, system register) may issue while bits are pending. They set the busy interlock, and `unit_done_i` clears it on the next edge. Classes 0, 6 and 7 leave the interlock untouched.
- R9: While `overlap_en_i` is low, `pend_o` is zero from the next edge on, no hazard check applies, and every issued instruction sets the busy interlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| overlap_en_i | input | 1 | 1 = hazard-tracked overlap, 0 = one instruction at a time |
| iss_valid_i | input | 1 | Decoder presents a request |
| iss_class_i | input | 3 | Unit class of the request |
| iss_dst_num_i | input | NDST*RW (10) | Destination register numbers, slot 0 in the low bits |
| iss_dst_vld_i | input | NDST (2) | Destination slot valid flags |
| iss_src_num_i | input | NSRC*RW (15) | Source register numbers, slot 0 in the low bits |
| iss_src_vld_i | input | NSRC (3) | Source slot valid flags |
| wb_vld_i | input | NWP (3) | Write-port completion strobes |
| wb_num_i | input | NWP*RW (15) | Register number completed by each write port |
| unit_done_i | input | 1 | The unit holding the busy interlock has finished |
| stall_o | output | 1 | The presented request may not issue this cycle |
| pend_o | output | NREG (32) | Pending-write bit per register |
| rd_num_o | output | NSRC*RW (15) | Captured source numbers, zero where invalid |
| rd_vld_o | output | NSRC (3) | Captured source valid flags |

## Verification
The bench covers these corner cases:
- **Write-after-write stall while a clear is in flight.** A completion arrives in the very stall cycle, so the request must issue one cycle later. A design that checks the wrong edge would issue early and drop the newer write.
- **One-source instruction after a two-source one.** The second source slot is invalid, but its stale number still points at a pending register. A design that ignores the valid flag would stall for no reason, or pass a stale read number forward.
- **Simultaneous completions on two ports.** Only OR-reduced clears remove both bits; a design where the last port overwrites the others leaves one bit stuck.
- **Set and clear of the same register in one cycle.** The clear must win. A set-priority latch would leave the bit stuck high forever.
- **Unit-class interlock cases.** The bench checks drain-before-issue against a pending vector that is not empty, and a completion that arrives in a busy cycle without releasing that cycle's request. It also checks that switching overlap off flushes bits that were still pending.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [2:0] {
    UC_ALU    = 3'd0,
    UC_MEM    = 3'd1,
    UC_BRANCH = 3'd2,
    UC_TRAP   = 3'd3,
    UC_XLATE  = 3'd4,
    UC_SYSREG = 3'd5
  } unit_class_e;

  // classes that must see an empty pending vector before they start
  function automatic logic cls_drains(input logic [2:0] cls);
    return (cls == UC_MEM) || (cls == UC_BRANCH) || (cls == UC_TRAP);
  endfunction

  // classes that hold the busy interlock while they execute
  function automatic logic cls_serial(input logic [2:0] cls);
    return cls_drains(cls) || (cls == UC_XLATE) || (cls == UC_SYSREG);
  endfunction

endpackage

// File: rtl/hz_onehot_or.sv
// Decodes several (valid, number) request pairs into one OR-reduced vector.
module hz_onehot_or #(
  parameter int NREG  = 32,
  parameter int NPORT = 2,
  parameter int RW    = 5
) (
  input  logic                  en_i,
  input  logic [NPORT-1:0]      vld_i,
  input  logic [NPORT*RW-1:0]   num_i,
  output logic [NREG-1:0]       vec_o
);
  localparam int NPAD = 1 << RW;

  logic [NPAD-1:0] vec_ext;

  always_comb begin
    vec_ext = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (en_i && vld_i[p]) vec_ext[num_i[p*RW +: RW]] = 1'b1;
    end
  end

  assign vec_o = vec_ext[NREG-1:0];

endmodule

// File: rtl/hz_rp_latch_vec.sv
// Vector of set/reset latches in which reset has priority over set.
module hz_rp_latch_vec #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (rst || flush_i) q <= 1'b0;
      else if (clr_i[i])  q <= 1'b0;
      else if (set_i[i])  q <= 1'b1;
    end
    assign q_o[i] = q;

    p_clr_wins_r3: assert property (@(posedge clk) disable iff (rst)
      clr_i[i] |=> !q_o[i]);
    p_set_takes_r2: assert property (@(posedge clk) disable iff (rst)
      (set_i[i] && !clr_i[i] && !flush_i) |=> q_o[i]);
  end

endmodule

// File: rtl/hz_issue_ctl.sv
// Stall decision, busy interlock and source capture.
module hz_issue_ctl
  import hz_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NDST = 2,
  parameter int NSRC = 3,
  parameter int RW   = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 overlap_en_i,
  input  logic                 iss_valid_i,
  input  logic [2:0]           iss_class_i,
  input  logic [NDST*RW-1:0]   iss_dst_num_i,
  input  logic [NDST-1:0]      iss_dst_vld_i,
  input  logic [NSRC*RW-1:0]   iss_src_num_i,
  input  logic [NSRC-1:0]      iss_src_vld_i,
  input  logic                 unit_done_i,
  input  logic [NREG-1:0]      pend_i,
  output logic                 stall_o,
  output logic                 accept_o,
  output logic [NSRC*RW-1:0]   rd_num_o,
  output logic [NSRC-1:0]      rd_vld_o
);
  localparam int NPAD = 1 << RW;

  logic [NPAD-1:0]     pend_ext;
  logic [NDST-1:0]     dst_hit;
  logic [NSRC-1:0]     src_hit;
  logic                busy_q;
  logic                hazard;
  logic [NSRC*RW-1:0]  rd_num_q;
  logic [NSRC-1:0]     rd_vld_q;

  assign pend_ext = NPAD'(pend_i);

  for (genvar d = 0; d < NDST; d++) begin : g_dst
    assign dst_hit[d] = iss_dst_vld_i[d] && pend_ext[iss_dst_num_i[d*RW +: RW]];
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_hit[s] = iss_src_vld_i[s] && pend_ext[iss_src_num_i[s*RW +: RW]];
  end

  // built only from registered state and the presented request, never from accept_o
  always_comb begin
    hazard = 1'b0;
    if (overlap_en_i) begin
      hazard = (|dst_hit) || (|src_hit) ||
               (cls_drains(iss_class_i) && (|pend_i));
    end
  end

  assign stall_o  = iss_valid_i && (busy_q || hazard);
  assign accept_o = iss_valid_i && !stall_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
    end else if (unit_done_i) begin
      busy_q <= 1'b0;
    end else if (accept_o && (!overlap_en_i || cls_serial(iss_class_i))) begin
      busy_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_num_q <= '0;
      rd_vld_q <= '0;
    end else if (accept_o) begin
      rd_vld_q <= iss_src_vld_i;
      for (int s = 0; s < NSRC; s++) begin
        rd_num_q[s*RW +: RW] <= iss_src_vld_i[s] ? iss_src_num_i[s*RW +: RW] : '0;
      end
    end
  end

  assign rd_num_o = rd_num_q;
  assign rd_vld_o = rd_vld_q;

  p_done_frees_r8: assert property (@(posedge clk) disable iff (rst)
    unit_done_i |=> !busy_q);
  p_busy_blocks_r8: assert property (@(posedge clk) disable iff (rst)
    (busy_q && iss_valid_i) |-> stall_o);
  p_drain_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (accept_o && overlap_en_i && cls_drains(iss_class_i)) |-> (pend_i == '0));
  p_src_capture_r6: assert property (@(posedge clk) disable iff (rst)
    accept_o |=> (rd_vld_o == $past(iss_src_vld_i)));

  for (genvar s = 0; s < NSRC; s++) begin : g_raw_chk
    p_no_raw_issue_r5: assert property (@(posedge clk) disable iff (rst)
      (accept_o && overlap_en_i && iss_src_vld_i[s])
        |-> !pend_ext[iss_src_num_i[s*RW +: RW]]);
  end

endmodule

// File: rtl/hz_scoreboard.sv
module hz_scoreboard
  import hz_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NDST = 2,
  parameter int NSRC = 3,
  parameter int NWP  = 3,
  parameter int RW   = $clog2(NREG)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 overlap_en_i,
  input  logic                 iss_valid_i,
  input  logic [2:0]           iss_class_i,
  input  logic [NDST*RW-1:0]   iss_dst_num_i,
  input  logic [NDST-1:0]      iss_dst_vld_i,
  input  logic [NSRC*RW-1:0]   iss_src_num_i,
  input  logic [NSRC-1:0]      iss_src_vld_i,
  input  logic [NWP-1:0]       wb_vld_i,
  input  logic [NWP*RW-1:0]    wb_num_i,
  input  logic                 unit_done_i,
  output logic                 stall_o,
  output logic [NREG-1:0]      pend_o,
  output logic [NSRC*RW-1:0]   rd_num_o,
  output logic [NSRC-1:0]      rd_vld_o
);
  localparam int NPAD = 1 << RW;

  logic            accept;
  logic [NREG-1:0] set_vec;
  logic [NREG-1:0] clr_vec;
  logic [NREG-1:0] pend_q;
  logic [NPAD-1:0] pend_ext;

  hz_issue_ctl #(.NREG(NREG), .NDST(NDST), .NSRC(NSRC), .RW(RW)) u_ctl (
    .clk           (clk),
    .rst           (rst),
    .overlap_en_i  (overlap_en_i),
    .iss_valid_i   (iss_valid_i),
    .iss_class_i   (iss_class_i),
    .iss_dst_num_i (iss_dst_num_i),
    .iss_dst_vld_i (iss_dst_vld_i),
    .iss_src_num_i (iss_src_num_i),
    .iss_src_vld_i (iss_src_vld_i),
    .unit_done_i   (unit_done_i),
    .pend_i        (pend_q),
    .stall_o       (stall_o),
    .accept_o      (accept),
    .rd_num_o      (rd_num_o),
    .rd_vld_o      (rd_vld_o)
  );

  hz_onehot_or #(.NREG(NREG), .NPORT(NDST), .RW(RW)) u_set (
    .en_i  (accept && overlap_en_i),
    .vld_i (iss_dst_vld_i),
    .num_i (iss_dst_num_i),
    .vec_o (set_vec)
  );

  hz_onehot_or #(.NREG(NREG), .NPORT(NWP), .RW(RW)) u_clr (
    .en_i  (1'b1),
    .vld_i (wb_vld_i),
    .num_i (wb_num_i),
    .vec_o (clr_vec)
  );

  hz_rp_latch_vec #(.N(NREG)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .flush_i (!overlap_en_i),
    .set_i   (set_vec),
    .clr_i   (clr_vec),
    .q_o     (pend_q)
  );

  assign pend_o   = pend_q;
  assign pend_ext = NPAD'(pend_q);

  p_flush_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !overlap_en_i |=> (pend_o == '0));

  for (genvar d = 0; d < NDST; d++) begin : g_waw_chk
    p_no_waw_issue_r4: assert property (@(posedge clk) disable iff (rst)
      (iss_valid_i && !stall_o && overlap_en_i && iss_dst_vld_i[d])
        |-> !pend_ext[iss_dst_num_i[d*RW +: RW]]);
  end

endmodule

// File: tb/tb_hz_scoreboard.sv
`timescale 1ns/1ps
module tb_hz_scoreboard;
  localparam int NREG = 32, NDST = 2, NSRC = 3, NWP = 3, RW = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic ovl = 1'b1, iv = 1'b0, done = 1'b0;
  logic [2:0] cls = '0;
  logic [NDST*RW-1:0] dn = '0;
  logic [NDST-1:0] dv = '0;
  logic [NSRC*RW-1:0] sn = '0;
  logic [NSRC-1:0] sv = '0;
  logic [NWP-1:0] wv = '0;
  logic [NWP*RW-1:0] wn = '0;
  logic stall;
  logic [NREG-1:0] pend;
  logic [NSRC*RW-1:0] rdn;
  logic [NSRC-1:0] rdv;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  hz_scoreboard #(.NREG(NREG), .NDST(NDST), .NSRC(NSRC), .NWP(NWP)) dut (
    .clk(clk), .rst(rst), .overlap_en_i(ovl), .iss_valid_i(iv), .iss_class_i(cls),
    .iss_dst_num_i(dn), .iss_dst_vld_i(dv), .iss_src_num_i(sn), .iss_src_vld_i(sv),
    .wb_vld_i(wv), .wb_num_i(wn), .unit_done_i(done), .stall_o(stall),
    .pend_o(pend), .rd_num_o(rdn), .rd_vld_o(rdv)
  );

  typedef struct {
    logic [NREG-1:0]    pend;
    logic [NSRC*RW-1:0] rdn;
    logic [NSRC-1:0]    rdv;
    string              tag;
  } exp_t;

  exp_t q[$];

  // bench reference state, built from the requirements
  logic [NREG-1:0]    m_pend = '0;
  logic               m_busy = 1'b0;
  logic [NSRC*RW-1:0] m_rdn = '0;
  logic [NSRC-1:0]    m_rdv = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic drains(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3;
  endfunction

  function automatic logic model_stall();
    logic s;
    if (!iv) return 1'b0;
    if (m_busy) return 1'b1;
    if (!ovl) return 1'b0;
    s = 1'b0;
    for (int d = 0; d < NDST; d++) if (dv[d] && m_pend[dn[d*RW +: RW]]) s = 1'b1;
    for (int k = 0; k < NSRC; k++) if (sv[k] && m_pend[sn[k*RW +: RW]]) s = 1'b1;
    if (drains(cls) && m_pend != '0) s = 1'b1;
    return s;
  endfunction

  // called right after a falling edge, once the inputs are driven
  task automatic step(input string tag);
    logic st, acc;
    logic [NREG-1:0] setv, clrv;
    exp_t e;
    #0.5;
    st = model_stall();
    chk({tag, " stall"}, 64'(stall), 64'(st));
    acc = iv && !st;
    setv = '0; clrv = '0;
    if (acc && ovl) for (int d = 0; d < NDST; d++) if (dv[d]) setv[dn[d*RW +: RW]] = 1'b1;
    for (int w = 0; w < NWP; w++) if (wv[w]) clrv[wn[w*RW +: RW]] = 1'b1;
    m_pend = ovl ? ((m_pend | setv) & ~clrv) : '0;
    if (done) m_busy = 1'b0;
    else if (acc && (!ovl || (cls >= 3'd1 && cls <= 3'd5))) m_busy = 1'b1;
    if (acc) begin
      m_rdv = sv;
      for (int k = 0; k < NSRC; k++) m_rdn[k*RW +: RW] = sv[k] ? sn[k*RW +: RW] : '0;
    end
    e.pend = m_pend; e.rdn = m_rdn; e.rdv = m_rdv; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compares the registered outputs after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " pend"}, 64'(pend), 64'(e.pend));
      chk({e.tag, " rd_vld"}, 64'(rdv), 64'(e.rdv));
      chk({e.tag, " rd_num"}, 64'(rdn), 64'(e.rdn));
    end
  end

  task automatic idle();
    @(negedge clk);
    iv = 0; cls = 0; dn = '0; dv = '0; sn = '0; sv = '0; wv = '0; wn = '0; done = 0;
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pend", 64'(pend), 64'(0));
    chk("R1 reset rd_vld", 64'(rdv), 64'(0));
    chk("R1 reset rd_num", 64'(rdn), 64'(0));
    chk("R1 reset stall", 64'(stall), 64'(0));
    rst = 0;
    idle(); step("R1 idle");

    idle(); iv = 1; dn = {5'd7, 5'd3}; dv = 2'b11; sn[4:0] = 5'd1; sv = 3'b001;
    step("R2 two dsts");
    idle(); iv = 1; dn = {5'd5, 5'd20}; dv = 2'b01;
    step("R2 invalid dst slot");
    idle(); iv = 1; dn[4:0] = 5'd3; dv = 2'b01;
    step("R4 waw stall");
    idle(); iv = 1; dn[4:0] = 5'd3; dv = 2'b01; wv = 3'b001; wn[4:0] = 5'd3;
    step("R4 stall while clearing");
    idle(); iv = 1; dn[4:0] = 5'd3; dv = 2'b01;
    step("R4 issue after clear");

    idle(); iv = 1; dn[4:0] = 5'd11; dv = 2'b01; sn = {5'd0, 5'd7, 5'd0}; sv = 3'b010;
    step("R5 raw stall");
    idle(); iv = 1; dn[4:0] = 5'd11; dv = 2'b01; sn = {5'd2, 5'd7, 5'd9}; sv = 3'b101;
    step("R5 R6 invalid source ignored");

    idle(); wv = 3'b101; wn = {5'd20, 5'd0, 5'd7};
    step("R3 two ports clear");
    idle(); iv = 1; dn[4:0] = 5'd12; dv = 2'b01; wv = 3'b010; wn = {5'd0, 5'd12, 5'd0};
    step("R3 clear wins over set");

    idle(); iv = 1; cls = 3'd1; dn[4:0] = 5'd13; dv = 2'b01;
    step("R7 drain stall");
    idle(); wv = 3'b011; wn = {5'd0, 5'd11, 5'd3};
    step("R3 drain pipeline");
    idle(); iv = 1; cls = 3'd1; dn[4:0] = 5'd13; dv = 2'b01; sn[4:0] = 5'd4; sv = 3'b001;
    step("R7 drain issue");
    idle(); iv = 1; dn[4:0] = 5'd14; dv = 2'b01;
    step("R7 busy blocks");
    idle(); iv = 1; dn[4:0] = 5'd14; dv = 2'b01; done = 1;
    step("R7 done same cycle");
    idle(); iv = 1; dn[4:0] = 5'd14; dv = 2'b01;
    step("R7 issue after done");

    idle(); iv = 1; cls = 3'd4; dn[4:0] = 5'd15; dv = 2'b01;
    step("R8 serial issue with pending");
    idle(); iv = 1; dn[4:0] = 5'd16; dv = 2'b01;
    step("R8 serial busy");
    idle(); done = 1;
    step("R8 done");
    idle(); iv = 1; cls = 3'd5;
    step("R8 sysreg issue");
    idle(); iv = 1; cls = 3'd0; dn[4:0] = 5'd17; dv = 2'b01;
    step("R8 sysreg busy");
    idle(); done = 1;
    step("R8 sysreg done");

    idle(); ovl = 0;
    step("R9 flush");
    idle(); ovl = 0; iv = 1; dn[4:0] = 5'd13; dv = 2'b01;
    step("R9 issue no tracking");
    idle(); ovl = 0; iv = 1; dn[4:0] = 5'd13; dv = 2'b01;
    step("R9 busy interlock");
    idle(); ovl = 0; done = 1;
    step("R9 done");
    idle(); ovl = 0; iv = 1; dn[4:0] = 5'd13; dv = 2'b01;
    step("R9 issue again");
    idle(); ovl = 0; done = 1;
    step("R9 final");

    idle(); idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule